// File: doc/BRIEF.md
# Serial Normalized Min-Sum Check Processor

This block is one processing element of a layered LDPC decoder that uses the normalized min-sum rule. For one parity-check row it takes the posterior value of each connected variable node, one per cycle. It removes the row's previous check message from each posterior to form the extrinsic value q. It tracks the two smallest extrinsic magnitudes, where the smallest one sits, and the parity of all signs. Once the row is complete, it scales both minima by 0.75. It then streams out one updated posterior per edge, in the same edge order, each one formed from the buffered q plus the new check message.

The previous check message of every row is held inside the block in compressed form: two scaled magnitudes, the edge index of the smaller, the total sign and one sign bit per edge. Every row starts from an all-zero state. The controller picks the row and its degree with a start pulse while `ready` is high. It then presents the posteriors with `in_valid`, and may leave gaps between them. The block walks four states:

- IDLE waits for `start`, then goes to ACCUM.
- ACCUM takes one edge on each cycle that has `in_valid`. After the last edge it goes to NORM.
- NORM lasts one cycle, scales the minima and writes back the row state. It then goes to EMIT.
- EMIT drives one output per cycle for `degree` cycles, then returns to IDLE.

Top module: `nms_check_proc`

## Requirements
- R1: After reset, `ready` is 1, `out_valid` and `out_last` are 0, and the stored state of every row is zero (every old message is 0).
- R2: For edge j, q = P − m_old, where P is the two's-complement input posterior and m_old is the row's stored message for edge j. q is clamped to [−128, 127].
- R3: The magnitude of q is |q|, except that q = −128 gives magnitude 127. The sign of q is its top bit (1 = negative).
- R4: Both minima start at 127 for each row pass. A magnitude strictly below min0 moves min0 into min1, becomes min0, and records its edge index. A magnitude that is not below min0 but is strictly below min1 replaces min1 only. Edge indices count from 0 in input order.
- R5: The total sign is the XOR of all q signs in the row. The sign of an edge's message is the total sign XOR that edge's own q sign (1 = negative).
- R6: After the last edge, r0 = min0 − (min0 >> 2) and r1 = min1 − (min1 >> 2).
- R7: The message magnitude is r1 on the edge whose index equals the recorded minimum index, and r0 on every other edge.
- R8: In EMIT, output k (k = 0 … degree−1, in input order) is q_k plus the new message, clamped to [−128, 127]. `out_valid` is high for exactly `degree` consecutive cycles, and `out_last` is high only on the final one.
- R9: `degree` (2 … 20) is captured on the start cycle. Exactly that many `in_valid` cycles are accepted before the row closes.
- R10: The compressed state is kept per row. A later pass on the same row subtracts the messages left by its previous pass, and passes on other rows do not disturb it.
- R11: `in_valid` is ignored outside ACCUM, and `start` is ignored outside IDLE.
- R12: `ready` is high only in IDLE. After the cycle that accepts the last edge comes exactly one NORM cycle with `out_valid` low, followed by EMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a row pass when `ready` is high |
| row_sel | input | 2 | Row whose compressed state is used and updated |
| degree | input | 5 | Number of edges in the row, 2 to 20 |
| in_valid | input | 1 | `in_post` carries the next edge's posterior |
| in_post | input | 8 | Posterior value, two's complement |
| ready | output | 1 | Block is idle and accepts `start` |
| out_valid | output | 1 | `out_post` carries an updated posterior |
| out_post | output | 8 | Updated posterior, two's complement |
| out_last | output | 1 | Marks the final output of the row |

## Verification
The assertions assume that the controller only issues `start` with a degree between 1 and 20. Given that, they check four things: the edge counter never reaches the degree while accumulating, min0 never exceeds min1, NORM always hands over to an active output, and a last output is always followed by an idle block. The stimulus keeps every degree between 2 and 20. It also provokes the states where inputs must be ignored: `in_valid` is held high while idle, during NORM and throughout EMIT, and a stray `start` for another row is driven in the middle of an accumulation. Random posteriors are mixed with directed rows of all-127, all −128 and tied magnitudes, and repeated passes on the same row exercise the removal of old messages.

// File: rtl/nms_pkg.sv
package nms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_NORM  = 2'd2,
        ST_EMIT  = 2'd3
    } nms_state_e;
endpackage

// File: rtl/nms_msg_build.sv
// Rebuilds one edge's check message from compressed row state.
module nms_msg_build #(
    parameter int W  = 8,
    parameter int MW = W - 1,
    parameter int IW = 5
) (
    input  logic [MW-1:0] r0,
    input  logic [MW-1:0] r1,
    input  logic [IW-1:0] min_idx,
    input  logic [IW-1:0] edge_idx,
    input  logic          tot_sign,
    input  logic          own_sign,
    output logic [W-1:0]  msg
);
    logic [MW-1:0] mag;
    logic [W-1:0]  pos;

    always_comb begin
        mag = (edge_idx == min_idx) ? r1 : r0;      // R7
        pos = {1'b0, mag};
        msg = (tot_sign ^ own_sign) ? (~pos + 1'b1) : pos;  // R5
    end
endmodule

// File: rtl/nms_min_track.sv
// Running first and second minimum with index of the first.
module nms_min_track #(
    parameter int MW = 7,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [MW-1:0] mag,
    input  logic [IW-1:0] edge_idx,
    output logic [MW-1:0] min0,
    output logic [MW-1:0] min1,
    output logic [IW-1:0] min_idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min0    <= '1;
            min1    <= '1;
            min_idx <= '0;
        end else if (clear) begin
            min0    <= '1;
            min1    <= '1;
            min_idx <= '0;
        end else if (en) begin
            if (mag < min0) begin
                min1    <= min0;
                min0    <= mag;
                min_idx <= edge_idx;
            end else if (mag < min1) begin
                min1 <= mag;
            end
        end
    end

    assert_min_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        min0 <= min1);

    assert_min_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && mag < min0) |=> (min1 == $past(min0)));
endmodule

// File: rtl/nms_row_store.sv
// Compressed check state, one entry per row.
module nms_row_store #(
    parameter int ROWS = 4,
    parameter int MW   = 7,
    parameter int IW   = 5,
    parameter int DMAX = 20,
    parameter int RW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   row,
    input  logic [MW-1:0]   wr_r0,
    input  logic [MW-1:0]   wr_r1,
    input  logic [IW-1:0]   wr_idx,
    input  logic            wr_tot,
    input  logic [DMAX-1:0] wr_sgn,
    output logic [MW-1:0]   rd_r0,
    output logic [MW-1:0]   rd_r1,
    output logic [IW-1:0]   rd_idx,
    output logic            rd_tot,
    output logic [DMAX-1:0] rd_sgn
);
    logic [MW-1:0]   r0_q  [ROWS];
    logic [MW-1:0]   r1_q  [ROWS];
    logic [IW-1:0]   idx_q [ROWS];
    logic            tot_q [ROWS];
    logic [DMAX-1:0] sgn_q [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r0_q[g]  <= '0;
                r1_q[g]  <= '0;
                idx_q[g] <= '0;
                tot_q[g] <= 1'b0;
                sgn_q[g] <= '0;
            end else if (we && row == RW'(g)) begin
                r0_q[g]  <= wr_r0;
                r1_q[g]  <= wr_r1;
                idx_q[g] <= wr_idx;
                tot_q[g] <= wr_tot;
                sgn_q[g] <= wr_sgn;
            end
        end
    end

    always_comb begin
        rd_r0  = r0_q[row];
        rd_r1  = r1_q[row];
        rd_idx = idx_q[row];
        rd_tot = tot_q[row];
        rd_sgn = sgn_q[row];
    end

    assert_scaled_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wr_r0 <= wr_r1));
endmodule

// File: rtl/nms_check_proc.sv
module nms_check_proc
    import nms_pkg::*;
#(
    parameter  int W    = 8,
    parameter  int DMAX = 20,
    parameter  int ROWS = 4,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DW   = $clog2(DMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] row_sel,
    input  logic [DW-1:0] degree,
    input  logic          in_valid,
    input  logic [W-1:0]  in_post,
    output logic          ready,
    output logic          out_valid,
    output logic [W-1:0]  out_post,
    output logic          out_last
);
    localparam int MW = W - 1;
    localparam int IW = (DMAX > 1) ? $clog2(DMAX) : 1;
    localparam logic [W-1:0] SMIN = {1'b1, {MW{1'b0}}};
    localparam logic [W-1:0] SMAX = {1'b0, {MW{1'b1}}};

    nms_state_e state_q, state_d;

    logic [DW-1:0]   deg_q;
    logic [RW-1:0]   row_q;
    logic [IW-1:0]   cnt_q;
    logic [W-1:0]    qbuf [DMAX];
    logic [DMAX-1:0] sgn_acc;
    logic            tot_acc;

    logic [MW-1:0]   st_r0, st_r1, min0, min1, r0_new, r1_new, q_mag;
    logic [IW-1:0]   st_idx, min_idx;
    logic            st_tot;
    logic [DMAX-1:0] st_sgn;
    logic [W-1:0]    msg, q_sat, q_neg;
    logic [W:0]      q_wide, sum_wide;
    logic            accept, last_edge, row_open;

    function automatic logic [W-1:0] clamp_w(input logic [W:0] v);
        if (v[W] ^ v[W-1]) return v[W] ? SMIN : SMAX;
        return v[W-1:0];
    endfunction

    // ---------------- helpers ----------------
    nms_row_store #(.ROWS(ROWS), .MW(MW), .IW(IW), .DMAX(DMAX), .RW(RW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(state_q == ST_NORM), .row(row_q),
        .wr_r0(r0_new), .wr_r1(r1_new), .wr_idx(min_idx),
        .wr_tot(tot_acc), .wr_sgn(sgn_acc),
        .rd_r0(st_r0), .rd_r1(st_r1), .rd_idx(st_idx),
        .rd_tot(st_tot), .rd_sgn(st_sgn)
    );

    // In ACCUM the store holds the old state; in EMIT it holds the new one.
    nms_msg_build #(.W(W), .MW(MW), .IW(IW)) u_msg (
        .r0(st_r0), .r1(st_r1), .min_idx(st_idx), .edge_idx(cnt_q),
        .tot_sign(st_tot), .own_sign(st_sgn[cnt_q]), .msg(msg)
    );

    nms_min_track #(.MW(MW), .IW(IW)) u_min (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_IDLE && start),
        .en(accept), .mag(q_mag), .edge_idx(cnt_q),
        .min0(min0), .min1(min1), .min_idx(min_idx)
    );

    // ---------------- datapath ----------------
    always_comb begin
        accept    = (state_q == ST_ACCUM) && in_valid;           // R11
        last_edge = (DW'(cnt_q) == deg_q - DW'(1));
        row_open  = (state_q == ST_ACCUM);
        q_wide    = {in_post[W-1], in_post} - {msg[W-1], msg};    // R2
        q_sat     = clamp_w(q_wide);
        q_neg     = ~q_sat + 1'b1;
        if (q_sat == SMIN)      q_mag = {MW{1'b1}};               // R3
        else if (q_sat[W-1])    q_mag = q_neg[MW-1:0];
        else                    q_mag = q_sat[MW-1:0];
        r0_new    = min0 - (min0 >> 2);                           // R6
        r1_new    = min1 - (min1 >> 2);
        sum_wide  = {qbuf[cnt_q][W-1], qbuf[cnt_q]} + {msg[W-1], msg};
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                state_d = ST_ACCUM;
            ST_ACCUM: if (accept && last_edge)  state_d = ST_NORM;
            ST_NORM:                            state_d = ST_EMIT;
            ST_EMIT:  if (last_edge)            state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // ---------------- row registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deg_q   <= '0;
            row_q   <= '0;
            cnt_q   <= '0;
            sgn_acc <= '0;
            tot_acc <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin          // R9: degree captured here
                    deg_q   <= degree;
                    row_q   <= row_sel;
                    cnt_q   <= '0;
                    sgn_acc <= '0;
                    tot_acc <= 1'b0;
                end
                ST_ACCUM: if (accept) begin
                    sgn_acc[cnt_q] <= q_sat[W-1];
                    tot_acc        <= tot_acc ^ q_sat[W-1];        // R5
                    cnt_q          <= last_edge ? '0 : cnt_q + 1'b1;
                end
                ST_NORM: cnt_q <= '0;
                ST_EMIT: cnt_q <= last_edge ? '0 : cnt_q + 1'b1;
                default: cnt_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) qbuf[cnt_q] <= q_sat;
    end

    // ---------------- outputs ----------------
    always_comb begin
        ready     = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_last  = (state_q == ST_EMIT) && last_edge;
        out_post  = (state_q == ST_EMIT) ? clamp_w(sum_wide) : '0;   // R8
    end

    // ---------------- assertions ----------------
    assert_deg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |-> (degree != '0 && degree <= DW'(DMAX)));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        row_open |-> (DW'(cnt_q) < deg_q));

    assert_norm_then_emit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM) |=> out_valid);

    assert_last_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (ready && !out_valid));
endmodule

// File: tb/nms_check_proc_test.sv
`timescale 1ns/1ps
module nms_check_proc_test;
    localparam int W = 8, DMAX = 20, ROWS = 4, RW = 2, DW = 5;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
    logic [RW-1:0] row_sel = '0;
    logic [DW-1:0] degree = '0;
    logic [W-1:0]  in_post = '0;
    logic ready, out_valid, out_last;
    logic [W-1:0] out_post;

    nms_check_proc #(.W(W), .DMAX(DMAX), .ROWS(ROWS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_sel(row_sel),
        .degree(degree), .in_valid(in_valid), .in_post(in_post),
        .ready(ready), .out_valid(out_valid), .out_post(out_post),
        .out_last(out_last)
    );

    always #2 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int m_r0[ROWS], m_r1[ROWS], m_idx[ROWS], m_tot[ROWS];
    bit m_sgn[ROWS][DMAX];
    int stim[DMAX], expv[DMAX];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clamp8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int edge_msg(input int row, input int j);
        int mag = (j == m_idx[row]) ? m_r1[row] : m_r0[row];
        return ((m_tot[row] ^ int'(m_sgn[row][j])) != 0) ? -mag : mag;
    endfunction

    task automatic model_row(input int row, input int deg);
        int q[DMAX];
        bit sg[DMAX];
        int mn0 = 127, mn1 = 127, mi = 0, tot = 0;
        for (int j = 0; j < DMAX; j++) begin q[j] = 0; sg[j] = 0; end
        for (int j = 0; j < deg; j++) begin
            int mag;
            q[j]  = clamp8(stim[j] - edge_msg(row, j));
            mag   = (q[j] == -128) ? 127 : (q[j] < 0 ? -q[j] : q[j]);
            sg[j] = (q[j] < 0);
            tot   = tot ^ int'(sg[j]);
            if (mag < mn0) begin mn1 = mn0; mn0 = mag; mi = j; end
            else if (mag < mn1) mn1 = mag;
        end
        m_r0[row] = mn0 - mn0 / 4;
        m_r1[row] = mn1 - mn1 / 4;
        m_idx[row] = mi;
        m_tot[row] = tot;
        for (int j = 0; j < DMAX; j++) m_sgn[row][j] = sg[j];
        for (int j = 0; j < deg; j++) expv[j] = clamp8(q[j] + edge_msg(row, j));
    endtask

    task automatic run_row(input int row, input int deg, input bit gaps,
                           input bit poke, input string tag);
        int i = 0;
        model_row(row, deg);
        @(negedge clk);
        in_valid = 1'b1; in_post = W'($urandom);   // idle: must be ignored (R11)
        @(negedge clk);
        start = 1'b1; row_sel = RW'(row); degree = DW'(deg); in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (i < deg) begin
            if (gaps && ($urandom % 4) == 0) begin
                in_valid = 1'b0; in_post = W'($urandom);
            end else begin
                in_valid = 1'b1; in_post = W'(stim[i]); i++;
            end
            if (poke && i == 1) begin          // stray start in ACCUM, R11
                start = 1'b1; row_sel = RW'(row ^ 1); degree = DW'(3);
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0; in_valid = 1'b1; in_post = W'($urandom);  // NORM: ignored
        check(out_valid == 1'b0 && ready == 1'b0, "R12 norm cycle", int'(out_valid), 0);
        @(negedge clk);
        for (int k = 0; k < deg; k++) begin
            check(out_valid == 1'b1, "R12 emit valid", int'(out_valid), 1);
            check($signed(out_post) == expv[k], tag, int'($signed(out_post)), expv[k]);
            check(out_last == (k == deg - 1), "R8 last flag", int'(out_last), int'(k == deg - 1));
            in_post = W'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(ready == 1'b1 && out_valid == 1'b0, "R12 back to idle", int'(ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int r = 0; r < ROWS; r++) begin
            m_r0[r] = 0; m_r1[r] = 0; m_idx[r] = 0; m_tot[r] = 0;
            for (int j = 0; j < DMAX; j++) m_sgn[r][j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        check(out_valid == 1'b0 && out_last == 1'b0, "R1 outputs quiet", int'(out_valid), 0);

        // R1 R8: zero state, positive saturation
        for (int j = 0; j < 4; j++) stim[j] = 127;
        run_row(0, 4, 0, 0, "R1 R8 positive clamp");
        // R3 R8: -128 magnitude and negative saturation
        for (int j = 0; j < 4; j++) stim[j] = -128;
        run_row(1, 4, 0, 0, "R3 R8 negative clamp");
        // R4 R7: min tracking and index selection
        stim[0] = 10; stim[1] = -3; stim[2] = 50; stim[3] = 5;
        run_row(2, 4, 0, 0, "R4 R7 minima");
        // R2 R10: same row again subtracts the stored messages
        run_row(2, 4, 0, 0, "R2 R10 old message");
        // R4: tied magnitudes
        for (int j = 0; j < 5; j++) stim[j] = (j % 2 == 0) ? 5 : -5;
        run_row(0, 5, 0, 0, "R4 ties");
        // R9 R11: full degree, gaps, stray start
        for (int j = 0; j < DMAX; j++) stim[j] = int'($signed(8'($urandom)));
        run_row(3, DMAX, 1, 1, "R9 R11 full degree");
        for (int j = 0; j < 2; j++) stim[j] = int'($signed(8'($urandom)));
        run_row(3, 2, 0, 0, "R9 minimum degree");
        // R5 R6 R10: random rows and degrees
        for (int t = 0; t < 40; t++) begin
            int row = int'($urandom % ROWS);
            int deg = 2 + int'($urandom % (DMAX - 1));
            for (int j = 0; j < deg; j++) stim[j] = int'($signed(8'($urandom % 256)));
            run_row(row, deg, t % 3 == 0, t % 7 == 0, "R5 R6 R10 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule